// File: doc/BRIEF.md
# Block-Linear Tiled Address Generator

This block walks a rectangle of pixels in raster order and produces, for each pixel, two byte offsets. One is the offset inside a surface stored in a tiled, block-linear layout. The other is the offset of the same pixel in a plain pitch-linear buffer. A copy datapath reads from one offset and writes to the other, so the block serves both tiling and untiling copies.

The tiled layout is built from tiles that are 64 bytes wide and 8 rows tall, giving 512 bytes per tile. Tiles are stacked vertically in groups of 2^bh to form a block. Blocks are placed side by side across the surface width. Inside a tile, the row and column bits are interleaved by a fixed swizzle.

A transfer is set up with a single start pulse, which captures all configuration inputs. The offsets are then issued one per cycle through a valid/ready handshake. A last flag marks the final pixel of the rectangle.

Top module: `gob_tile_addr_gen`

## Requirements
- R1: After reset, out_valid is 0 and stays 0 until a transfer is started.
- R2: A start pulse while idle, with nonzero rect_w and rect_h, captures the configuration. out_valid rises in the next cycle, and the first beat addresses pixel (org_x, org_y).
- R3: Beats are issued in raster order: x from 0 to rect_w-1 within a line, then lines 0 to rect_h-1. While out_valid is high and out_ready is low, all outputs hold.
- R4: The tiled offset row term depends on the surface row y = line + org_y. It is (y / (8<<bh)) * 512 * 2^bh * ceil(surf_w*bpp/64) + ((y mod (8<<bh)) / 8) * 512.
- R5: The tiled offset column term depends on the byte column xb = (x + org_x) * bpp. It is (xb / 64) * 512 * 2^bh. The tiled offset is the sum of the row term, the column term and the swizzle term of R6.
- R6: The swizzle term, for c = xb mod 64 and r = y mod 8, is laid out by bit position: bit 8 = c[5], bits 7:6 = r[2:1], bit 5 = c[4], bit 4 = r[0], bits 3:0 = c[3:0].
- R7: The linear offset is line * pitch + x * bpp.
- R8: out_last is 1 exactly on the final beat of the rectangle. After that beat is accepted, out_valid falls in the next cycle.
- R9: A start pulse or configuration change while a transfer is running is ignored. The remaining beats follow the captured configuration.
- R10: A start pulse with rect_w = 0 or rect_h = 0 produces no beats, and out_valid stays 0.
- R11: bpp_log2 encodes bytes per pixel as 1 << bpp_log2. The values 0 to 4 (1, 2, 4, 8 and 16 bytes) are supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer when idle |
| surf_w | input | 16 | Tiled surface width in pixels |
| pitch | input | 32 | Linear buffer line pitch in bytes |
| org_x | input | 16 | Rectangle origin x in the tiled surface |
| org_y | input | 16 | Rectangle origin y in the tiled surface |
| rect_w | input | 16 | Rectangle width in pixels |
| rect_h | input | 16 | Rectangle height in lines |
| bpp_log2 | input | 3 | log2 of bytes per pixel (0 to 4) |
| blk_h_log2 | input | 3 | log2 of tiles stacked per block |
| out_valid | output | 1 | Beat available |
| out_ready | input | 1 | Consumer accepts beat |
| out_tiled | output | 32 | Tiled byte offset |
| out_linear | output | 32 | Linear byte offset |
| out_last | output | 1 | Final beat of the rectangle |

## Verification
The bench builds the block with its default widths: 16-bit coordinates and 32-bit offsets. Within those widths it uses:
- every supported pixel size;
- block heights of 1 to 8 tiles;
- origins up to about 40 pixels;
- rectangles of up to 8 by 8 pixels.

With these values, rectangles cross tile columns, tile rows and block rows, and surface widths that are not a multiple of one tile row exercise the ceiling in the width term. Random ready stalls and start pulses issued during a transfer exercise output holding and configuration capture.

// File: rtl/gob_tile_pkg.sv
package gob_tile_pkg;
    parameter int CW  = 16;
    parameter int OW  = 32;
    parameter int BPW = 3;
    parameter int BHW = 3;

    localparam int TILE_X_SH = 6;
    localparam int TILE_Y_SH = 3;
    localparam int TILE_SH   = TILE_X_SH + TILE_Y_SH;

    typedef struct packed {
        logic [CW-1:0]  surf_w;
        logic [OW-1:0]  pitch;
        logic [CW-1:0]  org_x;
        logic [CW-1:0]  org_y;
        logic [CW-1:0]  rect_w;
        logic [CW-1:0]  rect_h;
        logic [BPW-1:0] bpp_log2;
        logic [BHW-1:0] bh;
    } tile_cfg_t;

    typedef struct packed {
        logic [OW-1:0] tiled;
        logic [OW-1:0] linear;
    } tile_offs_t;

    // bit interleave of byte column c and row r inside one tile
    function automatic logic [TILE_SH-1:0] tile_swizzle(input logic [TILE_X_SH-1:0] c,
                                                        input logic [TILE_Y_SH-1:0] r);
        return {c[5], r[2:1], c[4], r[0], c[3:0]};
    endfunction
endpackage

// File: rtl/tile_walker.sv
module tile_walker
    import gob_tile_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  tile_cfg_t     cfg_in,
    input  logic          ready,
    output logic          busy,
    output tile_cfg_t     cfg,
    output logic [CW-1:0] x,
    output logic [CW-1:0] line,
    output logic          last
);
    logic x_end;
    assign x_end = (x == cfg.rect_w - CW'(1));
    assign last  = x_end && (line == cfg.rect_h - CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cfg  <= '0;
            x    <= '0;
            line <= '0;
        end else if (!busy) begin
            if (start && cfg_in.rect_w != '0 && cfg_in.rect_h != '0) begin
                cfg  <= cfg_in;
                busy <= 1'b1;
                x    <= '0;
                line <= '0;
            end
        end else if (ready) begin
            if (last) begin
                busy <= 1'b0;
            end else if (x_end) begin
                x    <= '0;
                line <= line + CW'(1);
            end else begin
                x <= x + CW'(1);
            end
        end
    end

    // R3
    hold_stall_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !ready |=> busy && $stable(x) && $stable(line));
    // R3
    x_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> x < cfg.rect_w);
    // R8
    end_drop_chk: assert property (@(posedge clk) disable iff (rst)
        busy && ready && last |=> !busy);
    // R9
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy || $stable(cfg));
    // R10
    empty_rect_chk: assert property (@(posedge clk) disable iff (rst)
        !busy && start && (cfg_in.rect_w == '0 || cfg_in.rect_h == '0) |=> !busy);
endmodule

// File: rtl/tile_offset_calc.sv
module tile_offset_calc
    import gob_tile_pkg::*;
(
    input  tile_cfg_t     cfg,
    input  logic [CW-1:0] x,
    input  logic [CW-1:0] line,
    output tile_offs_t    offs
);
    logic [OW-1:0] xb, y, row_bytes, tiles_wide, blk_mask;
    logic [OW-1:0] row_term, mid_term, col_term, swz_term;

    always_comb begin
        xb         = (OW'(x) + OW'(cfg.org_x)) << cfg.bpp_log2;
        y          = OW'(line) + OW'(cfg.org_y);
        row_bytes  = OW'(cfg.surf_w) << cfg.bpp_log2;
        tiles_wide = (row_bytes + OW'((1 << TILE_X_SH) - 1)) >> TILE_X_SH;
        blk_mask   = (OW'(1) << cfg.bh) - OW'(1);
        row_term   = (y >> (TILE_Y_SH + int'(cfg.bh))) * (tiles_wide << (TILE_SH + int'(cfg.bh)));
        mid_term   = ((y >> TILE_Y_SH) & blk_mask) << TILE_SH;
        col_term   = (xb >> TILE_X_SH) << (TILE_SH + int'(cfg.bh));
        swz_term   = OW'(tile_swizzle(xb[TILE_X_SH-1:0], y[TILE_Y_SH-1:0]));
        offs.tiled  = row_term + mid_term + col_term + swz_term;
        offs.linear = OW'(line) * cfg.pitch + (OW'(x) << cfg.bpp_log2);
    end
endmodule

// File: rtl/gob_tile_addr_gen.sv
module gob_tile_addr_gen
    import gob_tile_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [CW-1:0]  surf_w,
    input  logic [OW-1:0]  pitch,
    input  logic [CW-1:0]  org_x,
    input  logic [CW-1:0]  org_y,
    input  logic [CW-1:0]  rect_w,
    input  logic [CW-1:0]  rect_h,
    input  logic [BPW-1:0] bpp_log2,
    input  logic [BHW-1:0] blk_h_log2,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [OW-1:0]  out_tiled,
    output logic [OW-1:0]  out_linear,
    output logic           out_last
);
    tile_cfg_t     cfg_in, cfg;
    tile_offs_t    offs;
    logic [CW-1:0] x, line;
    logic          busy, last;

    assign cfg_in = '{surf_w: surf_w, pitch: pitch, org_x: org_x, org_y: org_y,
                      rect_w: rect_w, rect_h: rect_h, bpp_log2: bpp_log2, bh: blk_h_log2};

    tile_walker u_walk (
        .clk(clk), .rst(rst), .start(start), .cfg_in(cfg_in), .ready(out_ready),
        .busy(busy), .cfg(cfg), .x(x), .line(line), .last(last)
    );

    tile_offset_calc u_calc (.cfg(cfg), .x(x), .line(line), .offs(offs));

    assign out_valid  = busy;
    assign out_tiled  = offs.tiled;
    assign out_linear = offs.linear;
    assign out_last   = busy && last;

    // R1
    reset_idle_chk: assert property (@(posedge clk) $past(rst) |-> !out_valid);
    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_tiled) && $stable(out_linear));
    // R8
    last_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);
endmodule

// File: tb/sim_gob_tile_addr_gen.sv
module sim_gob_tile_addr_gen;
    logic        clk = 0, rst = 1, start = 0, out_ready = 0;
    logic [15:0] surf_w = 0, org_x = 0, org_y = 0, rect_w = 0, rect_h = 0;
    logic [31:0] pitch = 0;
    logic [2:0]  bpp_log2 = 0, blk_h_log2 = 0;
    logic        out_valid, out_last;
    logic [31:0] out_tiled, out_linear;
    int tests = 0, fails = 0;

    always #5 clk = ~clk;

    gob_tile_addr_gen u0 (.*);

    function automatic longint ref_tiled(int sw, int bps, int bh, int ox, int oy, int x, int ln);
        longint bpp = 1 << bps, bhs = 1 << bh;
        longint xb = (x + ox) * bpp, y = ln + oy;
        longint wig = (sw * bpp + 63) / 64;
        longint c = xb % 64, r = y % 8;
        longint rowt = (y / (8 * bhs)) * 512 * bhs * wig + ((y % (8 * bhs)) / 8) * 512;
        longint colt = (xb / 64) * 512 * bhs;
        longint swz = ((c / 32) % 2) * 256 + ((r / 2) % 4) * 64 + ((c / 16) % 2) * 32
                    + (r % 2) * 16 + (c % 16);
        return rowt + colt + swz;
    endfunction

    task automatic check(bit ok, string tag, longint act, longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_case(int sw, int pt, int ox, int oy, int w, int h, int bps, int bh,
                            string tag);
        int idx = 0, total = w * h, guard = 0;
        @(negedge clk);
        surf_w = 16'(sw); pitch = 32'(pt); org_x = 16'(ox); org_y = 16'(oy);
        rect_w = 16'(w); rect_h = 16'(h); bpp_log2 = 3'(bps); blk_h_log2 = 3'(bh);
        start = 1;
        @(negedge clk);
        start = 0;
        if (total == 0) begin
            repeat (3) begin
                check(!out_valid, "R10 empty rectangle valid", longint'(out_valid), 0);
                @(negedge clk);
            end
            return;
        end
        while (idx < total && guard < 2000) begin
            int x = idx % w, ln = idx / w;
            longint et = ref_tiled(sw, bps, bh, ox, oy, x, ln);
            longint el = longint'(ln) * pt + (longint'(x) << bps);
            bit rdy;
            if (idx == 0)
                check(out_valid, {tag, " R2 first beat valid"}, longint'(out_valid), 1);
            check(out_valid && longint'(out_tiled) == et,
                  {tag, " R3 R4 R5 R6 tiled"}, longint'(out_tiled), et);
            check(longint'(out_linear) == el, {tag, " R7 linear"}, longint'(out_linear), el);
            check(out_last == (idx == total - 1), {tag, " R8 last"},
                  longint'(out_last), longint'(idx == total - 1));
            rdy = ($urandom % 4) != 0;
            out_ready = rdy;
            // R9: disturb config inputs and pulse start mid-transfer
            start = ($urandom % 3) == 0;
            surf_w = 16'($urandom); org_x = 16'($urandom); rect_w = 16'($urandom % 9);
            pitch = $urandom; bpp_log2 = 3'($urandom % 5); blk_h_log2 = 3'($urandom % 4);
            @(negedge clk);
            start = 0;
            if (rdy) idx++;
            guard++;
        end
        out_ready = 0;
        check(!out_valid, {tag, " R8 valid falls after last"}, longint'(out_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst = 0;
        check(!out_valid, "R1 idle after reset", longint'(out_valid), 0);
        @(negedge clk);
        check(!out_valid, "R1 idle without start", longint'(out_valid), 0);

        run_case(64, 64, 0, 0, 8, 8, 0, 0, "R6 bpp1 one tile");
        run_case(100, 40, 5, 13, 7, 6, 2, 2, "R4 bpp4 bh2 origin");
        run_case(33, 130, 3, 30, 5, 4, 4, 3, "R11 bpp16 bh3");
        run_case(17, 24, 60, 7, 8, 3, 1, 1, "R5 bpp2 column cross");
        run_case(10, 80, 2, 1, 4, 5, 3, 0, "R11 bpp8");
        run_case(50, 50, 0, 0, 0, 4, 0, 0, "R10 zero width");
        run_case(50, 50, 0, 0, 4, 0, 0, 0, "R10 zero height");
        run_case(9, 4, 0, 0, 1, 1, 2, 1, "R8 single pixel");

        for (int i = 0; i < 25; i++) begin
            int bps = $urandom % 5, w = 1 + $urandom % 8;
            run_case(1 + $urandom % 100, (w << bps) + $urandom % 16, $urandom % 40,
                     $urandom % 40, w, 1 + $urandom % 8, bps, $urandom % 4, "R3 random");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule